// File: doc/BRIEF.md
# Lifecycle transition controller

This block holds the lifecycle state of a device and performs one state change per power cycle. After reset it waits for a power-manager request that arrives together with valid state and counter data from a nonvolatile store. Once that data is accepted, the block reports ready, exposes the state and counter through registers, and drives a small set of broadcast enables that depend on the state.

Software requests a change by writing a target state and an unlock token, then writing a command strobe. The block checks three things: that the counter still has room, that the move is legal, and that the token matches the expected value supplied beside it. It then asks the nonvolatile model to record the new counter and the resulting state over a request/acknowledge pair, and reports the outcome in sticky status bits.

After any attempt, whether it succeeds or fails, the block stays locked until reset with its enables off. A failed program step, bad incoming data, an unknown internal state or a scrap escalation sends it to a terminal escalation state. A separate wipe escalation permanently raises the escalate-enable output.

Top module: `lcx_ctrl`

## Requirements
- R1: After reset `prog_req`, `bcast_en` and `escalate_en` are 0 and the status word (address 0) reads 0. A cycle with `pm_req` and `nv_valid` both high, carrying a known state code and a count of at most MAXCNT, makes the block ready (status bit 0). The state register (address 4) and the count register (address 5) then read the incoming values. Status bits: 0 ready, 1 success, 2 count error, 3 illegal move, 4 token error, 5 program error, 6 state error, 7 data error.
- R2: State codes are RAW 16'h5A3C, TEST 16'hA5C3, DEV 16'h3C5A, PROD 16'hC3A5, SCRAP 16'hF00F and ESC 16'h0FF0. While the block is ready, `bcast_en` is 4'b0000 for RAW, 4'b0011 for TEST, 4'b0110 for DEV, 4'b0100 for PROD and 4'b0000 for SCRAP.
- R3: A request is made by writing the target code to address 2, the token to addresses 6 (low word) and 7 (high word), and 1 in bit 0 of address 3. From the next cycle `prog_req` is high with `prog_cnt` equal to the count plus one, and the count register reads that value. `prog_req`, `prog_state` and `prog_cnt` stay constant until `prog_ack`.
- R4: Address 1 reads 1 while a program step is pending. Writes to addresses 2, 3, 6 and 7 are ignored whenever the block is not ready. `bcast_en` is 0 from the cycle after a request is accepted.
- R5: After any attempt, a further command is ignored until reset: `prog_req` stays low and the count does not change. An acknowledged, error-free program step of a legal, token-matched move sets status bit 1.
- R6: A command while the count equals MAXCNT (16) sets bit 2, skips the program step and locks the block.
- R7: A move is legal only to a known state later in the order RAW, TEST, DEV, PROD, SCRAP, and never out of SCRAP. An illegal move sets bit 3, still programs the incremented count with `prog_state` equal to the current state, and leaves bit 1 clear.
- R8: Every legal move except one into SCRAP needs the token to equal `exp_token`. A mismatch sets bit 4 and programs the current state. A move into SCRAP succeeds with any token.
- R9: `prog_fail` together with `prog_ack` sets bit 5, raises `alert_prog`, makes the state register read ESC and raises `escalate_en`. All of these hold until reset.
- R10: Incoming data with an unknown state code or a count above MAXCNT sets bit 6, raises `alert_state` and `escalate_en`, and makes the state register read ESC. All of these hold until reset.
- R11: Status bit 7 follows `nv_err` one cycle later and clears when `nv_err` falls, without a reset.
- R12: A pulse on `esc_wipe` raises `escalate_en` until reset and leaves the block ready.
- R13: A pulse on `esc_scrap` forces the escalation state until reset. The state register reads ESC, ready drops, `bcast_en` is 0 two cycles later, `escalate_en` rises and commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| pm_req | input | 1 | Power-manager initialisation request |
| nv_valid | input | 1 | Incoming state and count data valid |
| nv_state | input | 16 | Incoming state code |
| nv_cnt | input | CW | Incoming transition count |
| nv_err | input | 1 | Error flag on incoming data |
| exp_token | input | TW | Expected unlock token |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | AW | Register write address |
| reg_wdata | input | DW | Register write data |
| reg_raddr | input | AW | Register read address |
| reg_rdata | output | DW | Register read data, one cycle after the address |
| prog_req | output | 1 | Program request to the nonvolatile model |
| prog_state | output | 16 | State code to record |
| prog_cnt | output | CW | Count to record |
| prog_ack | input | 1 | Program step finished |
| prog_fail | input | 1 | Program step failed, qualified by `prog_ack` |
| esc_wipe | input | 1 | Wipe escalation |
| esc_scrap | input | 1 | Scrap escalation |
| bcast_en | output | 4 | State-dependent broadcast enables |
| escalate_en | output | 1 | Permanent escalate enable |
| alert_prog | output | 1 | Program-failure alert |
| alert_state | output | 1 | State-failure alert |

## Verification
The handshake property assumes `prog_ack` is high only while `prog_req` is high. The bench raises it only after it has seen the request and drops it the next cycle. The properties also assume `esc_scrap` and `esc_wipe` are single-cycle pulses and that `pm_req`/`nv_valid` come while the block waits for data, so the stimulus pulses each of them once per scenario and resets between scenarios. Each scenario starts from a fresh reset, because every attempt locks the block by design.

// File: rtl/lcx_pkg.sv
`timescale 1ns/1ps
package lcx_pkg;
  localparam int SW = 16;
  localparam int NB = 4;

  localparam logic [SW-1:0] ST_RAW   = 16'h5A3C;
  localparam logic [SW-1:0] ST_TEST  = 16'hA5C3;
  localparam logic [SW-1:0] ST_DEV   = 16'h3C5A;
  localparam logic [SW-1:0] ST_PROD  = 16'hC3A5;
  localparam logic [SW-1:0] ST_SCRAP = 16'hF00F;
  localparam logic [SW-1:0] ST_ESC   = 16'h0FF0;

  localparam logic [2:0] RK_SCRAP = 3'd4;
  localparam logic [2:0] RK_BAD   = 3'd7;

  // register addresses
  localparam int A_STAT  = 0;
  localparam int A_BUSY  = 1;
  localparam int A_TGT   = 2;
  localparam int A_CMD   = 3;
  localparam int A_STATE = 4;
  localparam int A_CNT   = 5;
  localparam int A_TOK0  = 6;

  // controller states, spread apart in Hamming distance
  typedef enum logic [5:0] {
    F_BOOT = 6'b000111,
    F_IDLE = 6'b011100,
    F_PROG = 6'b110001,
    F_POST = 6'b101010,
    F_ESC  = 6'b111111
  } fsm_e;

  typedef struct packed {
    logic data_err;
    logic state_err;
    logic prog_err;
    logic token_err;
    logic trans_err;
    logic cnt_err;
    logic done_ok;
    logic ready;
  } stat_t;

  function automatic logic [2:0] st_rank(input logic [SW-1:0] s);
    case (s)
      ST_RAW:   return 3'd0;
      ST_TEST:  return 3'd1;
      ST_DEV:   return 3'd2;
      ST_PROD:  return 3'd3;
      ST_SCRAP: return RK_SCRAP;
      default:  return RK_BAD;
    endcase
  endfunction

  function automatic logic [NB-1:0] st_bcast(input logic [SW-1:0] s);
    case (s)
      ST_TEST: return 4'b0011;
      ST_DEV:  return 4'b0110;
      ST_PROD: return 4'b0100;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/lcx_regs.sv
`timescale 1ns/1ps
module lcx_regs
  import lcx_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32,
  parameter int TW = 64,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  input  logic          lock,
  input  logic          busy,
  input  stat_t         stat,
  input  logic [SW-1:0] state_rd,
  input  logic [CW-1:0] cnt,
  output logic [DW-1:0] rdata,
  output logic [SW-1:0] target,
  output logic [TW-1:0] token,
  output logic          go
);
  localparam int NTOK = (TW + DW - 1) / DW;

  logic              wr_ok;
  logic [NTOK*DW-1:0] tokcat;

  assign wr_ok = we & ~lock;
  assign go    = wr_ok && (waddr == AW'(A_CMD)) && wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      target <= '0;
    end else if (wr_ok && waddr == AW'(A_TGT)) begin
      target <= wdata[SW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tokcat <= '0;
    end else begin
      for (int i = 0; i < NTOK; i++) begin
        if (wr_ok && waddr == AW'(A_TOK0 + i)) tokcat[i*DW +: DW] <= wdata;
      end
    end
  end

  assign token = tokcat[TW-1:0];

  // tokens are write-only and read back as zero
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      case (raddr)
        AW'(A_STAT):  rdata <= DW'(stat);
        AW'(A_BUSY):  rdata <= DW'(busy);
        AW'(A_TGT):   rdata <= DW'(target);
        AW'(A_STATE): rdata <= DW'(state_rd);
        AW'(A_CNT):   rdata <= DW'(cnt);
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/lcx_fsm.sv
`timescale 1ns/1ps
module lcx_fsm
  import lcx_pkg::*;
#(
  parameter int CW     = 5,
  parameter int TW     = 64,
  parameter int MAXCNT = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pm_req,
  input  logic          nv_valid,
  input  logic [SW-1:0] nv_state,
  input  logic [CW-1:0] nv_cnt,
  input  logic          nv_err,
  input  logic          go,
  input  logic [SW-1:0] target,
  input  logic [TW-1:0] token,
  input  logic [TW-1:0] exp_token,
  input  logic          prog_ack,
  input  logic          prog_fail,
  input  logic          esc_wipe,
  input  logic          esc_scrap,
  output fsm_e          fsm,
  output stat_t         stat,
  output logic [SW-1:0] cur_state,
  output logic [CW-1:0] cnt,
  output logic          prog_req,
  output logic [SW-1:0] prog_state,
  output logic [CW-1:0] prog_cnt,
  output logic          escalate_en,
  output logic          alert_prog,
  output logic          alert_state
);
  logic       nv_err_q, pend_ok;
  logic       done_ok, cnt_err, trans_err, token_err, prog_err, state_err;
  logic [2:0] rk_cur, rk_tgt;
  logic       legal, need_tok, bad_init;

  assign rk_cur   = st_rank(cur_state);
  assign rk_tgt   = st_rank(target);
  assign legal    = (rk_tgt != RK_BAD) && (rk_cur != RK_SCRAP) && (rk_tgt > rk_cur);
  assign need_tok = (target != ST_SCRAP);
  assign bad_init = (st_rank(nv_state) == RK_BAD) || (nv_cnt > CW'(MAXCNT));

  always_comb begin
    stat           = '0;
    stat.ready     = (fsm == F_IDLE);
    stat.done_ok   = done_ok;
    stat.cnt_err   = cnt_err;
    stat.trans_err = trans_err;
    stat.token_err = token_err;
    stat.prog_err  = prog_err;
    stat.state_err = state_err;
    stat.data_err  = nv_err_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm         <= F_BOOT;
      cur_state   <= ST_RAW;
      cnt         <= '0;
      prog_req    <= 1'b0;
      prog_state  <= '0;
      prog_cnt    <= '0;
      escalate_en <= 1'b0;
      alert_prog  <= 1'b0;
      alert_state <= 1'b0;
      nv_err_q    <= 1'b0;
      pend_ok     <= 1'b0;
      done_ok     <= 1'b0;
      cnt_err     <= 1'b0;
      trans_err   <= 1'b0;
      token_err   <= 1'b0;
      prog_err    <= 1'b0;
      state_err   <= 1'b0;
    end else begin
      nv_err_q <= nv_err;
      if (esc_wipe) escalate_en <= 1'b1;
      if (esc_scrap) begin
        fsm         <= F_ESC;
        prog_req    <= 1'b0;
        escalate_en <= 1'b1;
      end else begin
        case (fsm)
          F_BOOT: begin
            if (pm_req && nv_valid) begin
              if (bad_init) begin
                fsm         <= F_ESC;
                state_err   <= 1'b1;
                alert_state <= 1'b1;
                escalate_en <= 1'b1;
              end else begin
                cur_state <= nv_state;
                cnt       <= nv_cnt;
                fsm       <= F_IDLE;
              end
            end
          end
          F_IDLE: begin
            if (go) begin
              if (cnt == CW'(MAXCNT)) begin
                cnt_err <= 1'b1;
                fsm     <= F_POST;
              end else begin
                cnt      <= cnt + CW'(1);
                prog_cnt <= cnt + CW'(1);
                prog_req <= 1'b1;
                fsm      <= F_PROG;
                if (!legal) begin
                  trans_err  <= 1'b1;
                  prog_state <= cur_state;
                  pend_ok    <= 1'b0;
                end else if (need_tok && token != exp_token) begin
                  token_err  <= 1'b1;
                  prog_state <= cur_state;
                  pend_ok    <= 1'b0;
                end else begin
                  prog_state <= target;
                  pend_ok    <= 1'b1;
                end
              end
            end
          end
          F_PROG: begin
            if (prog_ack) begin
              prog_req <= 1'b0;
              if (prog_fail) begin
                prog_err    <= 1'b1;
                alert_prog  <= 1'b1;
                escalate_en <= 1'b1;
                fsm         <= F_ESC;
              end else begin
                done_ok <= pend_ok;
                fsm     <= F_POST;
              end
            end
          end
          F_POST: ;
          F_ESC:  ;
          default: begin
            // unknown encoding of the controller itself
            fsm         <= F_ESC;
            state_err   <= 1'b1;
            alert_state <= 1'b1;
            escalate_en <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/lcx_bcast.sv
`timescale 1ns/1ps
module lcx_bcast
  import lcx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  fsm_e          fsm,
  input  logic [SW-1:0] cur_state,
  output logic [NB-1:0] bcast
);
  logic [NB-1:0] map;
  assign map = st_bcast(cur_state);

  for (genvar b = 0; b < NB; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) bcast[b] <= 1'b0;
      else     bcast[b] <= (fsm == F_IDLE) & map[b];
    end
  end
endmodule

// File: rtl/lcx_ctrl.sv
`timescale 1ns/1ps
module lcx_ctrl
  import lcx_pkg::*;
#(
  parameter int AW     = 3,
  parameter int DW     = 32,
  parameter int TW     = 64,
  parameter int CW     = 5,
  parameter int MAXCNT = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pm_req,
  input  logic          nv_valid,
  input  logic [15:0]   nv_state,
  input  logic [CW-1:0] nv_cnt,
  input  logic          nv_err,
  input  logic [TW-1:0] exp_token,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_waddr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [AW-1:0] reg_raddr,
  output logic [DW-1:0] reg_rdata,
  output logic          prog_req,
  output logic [15:0]   prog_state,
  output logic [CW-1:0] prog_cnt,
  input  logic          prog_ack,
  input  logic          prog_fail,
  input  logic          esc_wipe,
  input  logic          esc_scrap,
  output logic [3:0]    bcast_en,
  output logic          escalate_en,
  output logic          alert_prog,
  output logic          alert_state
);
  fsm_e          fsm;
  stat_t         stat;
  logic [SW-1:0] cur_state, target, state_rd;
  logic [CW-1:0] cnt;
  logic [TW-1:0] token;
  logic          go, lock, busy;

  assign lock     = (fsm != F_IDLE);
  assign busy     = (fsm == F_PROG);
  assign state_rd = (fsm == F_ESC) ? ST_ESC : cur_state;

  lcx_regs #(.AW(AW), .DW(DW), .TW(TW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .lock(lock), .busy(busy), .stat(stat),
    .state_rd(state_rd), .cnt(cnt), .rdata(reg_rdata), .target(target),
    .token(token), .go(go)
  );

  lcx_fsm #(.CW(CW), .TW(TW), .MAXCNT(MAXCNT)) u_fsm (
    .clk(clk), .rst(rst), .pm_req(pm_req), .nv_valid(nv_valid),
    .nv_state(nv_state), .nv_cnt(nv_cnt), .nv_err(nv_err), .go(go),
    .target(target), .token(token), .exp_token(exp_token),
    .prog_ack(prog_ack), .prog_fail(prog_fail), .esc_wipe(esc_wipe),
    .esc_scrap(esc_scrap), .fsm(fsm), .stat(stat), .cur_state(cur_state),
    .cnt(cnt), .prog_req(prog_req), .prog_state(prog_state),
    .prog_cnt(prog_cnt), .escalate_en(escalate_en), .alert_prog(alert_prog),
    .alert_state(alert_state)
  );

  lcx_bcast u_bcast (
    .clk(clk), .rst(rst), .fsm(fsm), .cur_state(cur_state), .bcast(bcast_en)
  );
endmodule

// File: rtl/lcx_chk.sv
`timescale 1ns/1ps
module lcx_chk #(
  parameter int CW     = 5,
  parameter int MAXCNT = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          prog_req,
  input logic          prog_ack,
  input logic [15:0]   prog_state,
  input logic [CW-1:0] prog_cnt,
  input logic          esc_scrap,
  input logic [3:0]    bcast_en,
  input logic          escalate_en,
  input logic          alert_prog,
  input logic          alert_state
);
  assert_prog_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (prog_req && !prog_ack && !esc_scrap) |=> (prog_req && $stable(prog_state) && $stable(prog_cnt)));

  assert_bcast_off_R4: assert property (@(posedge clk) disable iff (rst)
    $past(prog_req) |-> (bcast_en == 4'b0000));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    prog_req |-> (prog_cnt <= CW'(MAXCNT)));

  assert_alert_prog_R9: assert property (@(posedge clk) disable iff (rst)
    alert_prog |=> alert_prog);

  assert_alert_state_R10: assert property (@(posedge clk) disable iff (rst)
    alert_state |=> alert_state);

  assert_escalate_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    escalate_en |=> escalate_en);

  assert_scrap_R13: assert property (@(posedge clk) disable iff (rst)
    esc_scrap |=> ##1 (bcast_en == 4'b0000 && escalate_en));
endmodule

bind lcx_ctrl lcx_chk #(.CW(CW), .MAXCNT(MAXCNT)) u_chk (
  .clk(clk), .rst(rst), .prog_req(prog_req), .prog_ack(prog_ack),
  .prog_state(prog_state), .prog_cnt(prog_cnt), .esc_scrap(esc_scrap),
  .bcast_en(bcast_en), .escalate_en(escalate_en), .alert_prog(alert_prog),
  .alert_state(alert_state)
);

// File: tb/sim_lcx_ctrl.sv
`timescale 1ns/1ps
module sim_lcx_ctrl;
  localparam logic [15:0] RAW = 16'h5A3C, TEST = 16'hA5C3, DEV = 16'h3C5A;
  localparam logic [15:0] PROD = 16'hC3A5, SCRAP = 16'hF00F, ESC = 16'h0FF0;
  localparam logic [63:0] TOKEN = 64'h0123_4567_89AB_CDEF;

  logic clk = 0, rst = 1;
  logic pm_req = 0, nv_valid = 0, nv_err = 0;
  logic [15:0] nv_state = 0;
  logic [4:0] nv_cnt = 0;
  logic reg_we = 0;
  logic [2:0] reg_waddr = 0, reg_raddr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic prog_req, prog_ack = 0, prog_fail = 0;
  logic [15:0] prog_state;
  logic [4:0] prog_cnt;
  logic esc_wipe = 0, esc_scrap = 0;
  logic [3:0] bcast_en;
  logic escalate_en, alert_prog, alert_state;

  int total = 0, bad = 0, cyc = 0;
  bit fin = 0;
  int    due_q[$];
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcx_ctrl u0 (
    .clk(clk), .rst(rst), .pm_req(pm_req), .nv_valid(nv_valid),
    .nv_state(nv_state), .nv_cnt(nv_cnt), .nv_err(nv_err), .exp_token(TOKEN),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .prog_req(prog_req),
    .prog_state(prog_state), .prog_cnt(prog_cnt), .prog_ack(prog_ack),
    .prog_fail(prog_fail), .esc_wipe(esc_wipe), .esc_scrap(esc_scrap),
    .bcast_en(bcast_en), .escalate_en(escalate_en), .alert_prog(alert_prog),
    .alert_state(alert_state)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares register reads once their data is due
  always @(negedge clk) begin
    if (due_q.size() > 0 && due_q[0] <= cyc) begin
      chk(tag_q[0], reg_rdata, exp_q[0]);
      void'(due_q.pop_front());
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  // driver: issue a read and queue its expected value
  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_raddr = a;
    due_q.push_back(cyc + 1);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic init(input logic [15:0] s, input logic [4:0] c);
    @(negedge clk);
    pm_req = 1; nv_valid = 1; nv_state = s; nv_cnt = c;
    @(negedge clk);
    pm_req = 0; nv_valid = 0;
    @(negedge clk);
  endtask

  task automatic request(input logic [15:0] tgt, input logic [63:0] tok);
    wr(3'd2, {16'h0, tgt});
    wr(3'd6, tok[31:0]);
    wr(3'd7, tok[63:32]);
    wr(3'd3, 32'h1);
  endtask

  task automatic ack(input logic fail);
    @(negedge clk);
    prog_ack = 1; prog_fail = fail;
    @(negedge clk);
    prog_ack = 0; prog_fail = 0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state and init
    do_reset();
    chk("R1 prog_req after reset", 32'(prog_req), 0);
    chk("R1 bcast after reset", 32'(bcast_en), 0);
    chk("R1 escalate after reset", 32'(escalate_en), 0);
    rd(3'd0, 32'h00, "R1 status before init");
    init(TEST, 5'd3);
    chk("R2 bcast TEST", 32'(bcast_en), 32'b0011);
    rd(3'd0, 32'h01, "R1 status ready");
    rd(3'd4, 32'(TEST), "R1 state register");
    rd(3'd5, 32'd3, "R1 count register");
    // R3 good request TEST -> DEV
    request(DEV, TOKEN);
    chk("R3 prog_req", 32'(prog_req), 1);
    chk("R3 prog_state", 32'(prog_state), 32'(DEV));
    chk("R3 prog_cnt", 32'(prog_cnt), 4);
    rd(3'd1, 32'h1, "R4 busy reads 1");
    chk("R4 bcast off while busy", 32'(bcast_en), 0);
    wr(3'd2, 32'(PROD));
    rd(3'd2, 32'(DEV), "R4 target write blocked");
    rd(3'd5, 32'd4, "R3 count incremented");
    chk("R3 prog_req held", 32'(prog_req), 1);
    ack(1'b0);
    chk("R5 prog_req dropped", 32'(prog_req), 0);
    rd(3'd0, 32'h02, "R5 success bit");
    rd(3'd1, 32'h0, "R4 busy cleared");
    wr(3'd3, 32'h1);
    chk("R5 second command ignored", 32'(prog_req), 0);
    rd(3'd5, 32'd4, "R5 count unchanged");
    drain();

    // R7 illegal move DEV -> RAW
    do_reset();
    init(DEV, 5'd2);
    chk("R2 bcast DEV", 32'(bcast_en), 32'b0110);
    request(RAW, TOKEN);
    chk("R7 prog_req", 32'(prog_req), 1);
    chk("R7 prog_state current", 32'(prog_state), 32'(DEV));
    chk("R7 prog_cnt", 32'(prog_cnt), 3);
    ack(1'b0);
    rd(3'd0, 32'h08, "R7 illegal status");
    drain();

    // R8 token mismatch TEST -> PROD
    do_reset();
    init(TEST, 5'd0);
    request(PROD, ~TOKEN);
    chk("R8 prog_state current", 32'(prog_state), 32'(TEST));
    ack(1'b0);
    rd(3'd0, 32'h10, "R8 token status");
    drain();

    // R8 unconditional move into SCRAP
    do_reset();
    init(PROD, 5'd5);
    chk("R2 bcast PROD", 32'(bcast_en), 32'b0100);
    request(SCRAP, 64'h0);
    chk("R8 scrap prog_state", 32'(prog_state), 32'(SCRAP));
    chk("R8 scrap prog_cnt", 32'(prog_cnt), 6);
    ack(1'b0);
    rd(3'd0, 32'h02, "R8 scrap success");
    drain();

    // R6 count exhausted
    do_reset();
    init(TEST, 5'd16);
    request(DEV, TOKEN);
    chk("R6 no program", 32'(prog_req), 0);
    rd(3'd0, 32'h04, "R6 count error");
    rd(3'd5, 32'd16, "R6 count kept");
    drain();

    // R9 program failure
    do_reset();
    init(RAW, 5'd1);
    chk("R2 bcast RAW", 32'(bcast_en), 0);
    request(TEST, TOKEN);
    ack(1'b1);
    chk("R9 alert_prog", 32'(alert_prog), 1);
    chk("R9 escalate", 32'(escalate_en), 1);
    rd(3'd0, 32'h20, "R9 status");
    rd(3'd4, 32'(ESC), "R9 state ESC");
    drain();

    // R10 invalid incoming data
    do_reset();
    init(16'h1234, 5'd0);
    chk("R10 alert_state", 32'(alert_state), 1);
    chk("R10 escalate", 32'(escalate_en), 1);
    rd(3'd0, 32'h40, "R10 status bad code");
    rd(3'd4, 32'(ESC), "R10 state ESC");
    drain();
    do_reset();
    init(TEST, 5'd17);
    rd(3'd0, 32'h40, "R10 status bad count");
    drain();

    // R11 data error flag, R12 wipe, R13 scrap
    do_reset();
    init(TEST, 5'd0);
    nv_err = 1;
    rd(3'd0, 32'h81, "R11 data error set");
    nv_err = 0;
    rd(3'd0, 32'h01, "R11 data error clears");
    @(negedge clk);
    esc_wipe = 1;
    @(negedge clk);
    esc_wipe = 0;
    repeat (2) @(negedge clk);
    chk("R12 escalate held", 32'(escalate_en), 1);
    rd(3'd0, 32'h01, "R12 still ready");
    drain();
    @(negedge clk);
    esc_scrap = 1;
    @(negedge clk);
    esc_scrap = 0;
    @(negedge clk);
    chk("R13 bcast off", 32'(bcast_en), 0);
    chk("R13 escalate", 32'(escalate_en), 1);
    rd(3'd4, 32'(ESC), "R13 state ESC");
    rd(3'd0, 32'h00, "R13 not ready");
    wr(3'd3, 32'h1);
    chk("R13 command ignored", 32'(prog_req), 0);
    drain();

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule